// File: doc/BRIEF.md
# Parallel Port FIFO Control and Status Register

This block holds the extended control register of a bidirectional parallel port whose data passes through a byte FIFO. Software writes a 3-bit operating-mode field and a 5-bit reserved field through a small register bus. The FIFO status bits it reads back are built from the FIFO's occupancy count and the transfer direction. The same bit can mean "no bytes held" or "fewer than one byte held", and "free space reached the threshold" or "held data reached the threshold", depending on which way the data flows.

A second, read-only configuration register can be seen only while the mode field selects configuration mode. In every other mode it reads as zero. While the mode field selects FIFO mode, the block also raises a one-cycle service interrupt each time the service condition becomes true. An error output shows when the stored control value breaks a software rule: either a reserved mode code or a reserved field other than the required pattern.

Top module: `ppfifo_ctrl`

## Requirements
- R1: After synchronous reset the mode field is 000 and the reserved field holds 00001. A read of address 0 then shows bits [7:3] = 00000 and mode_err = 0.
- R2: A write strobe at address 0 stores wdata[7:5] as the mode and wdata[4:0] as the reserved field, effective from the next clock edge. A read of address 0 returns {mode, reserved[4:3], service, full, empty}. Without such a write the stored value does not change.
- R3: Bit 0 of address 0 (empty) is 1 exactly when the occupancy count is 0, in both directions (dir_rev = 0 forward, 1 reverse).
- R4: Bit 1 of address 0 (full) is 1 exactly when the occupancy count equals the FIFO depth of 16, in both directions.
- R5: Bit 2 of address 0 (service) depends on direction. Forward: 1 when the free space (16 minus the count) is 8 or more. Reverse: 1 when the count is 8 or more.
- R6: Address 1 reads {1'b0, port_irq, 6'b0} while the mode is 111 and 8'h00 in any other mode. Writes to address 1 leave the control register unchanged.
- R7: mode_err is 1 while the stored mode is reserved (010 or 101) or the stored reserved field differs from 00001. The value is still stored.
- R8: svc_irq is high for exactly one cycle in each cycle where the service condition is true, was false in the previous cycle, and the mode is 011. It is never high in any other mode.
- R9: rdata is 8'h00 whenever rd_en is low and for addresses 2 and 3. Reads are combinational from the current state and inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address (0 control/status, 1 configuration) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| fifo_count | input | 5 | Bytes held in the FIFO, 0 to 16 |
| dir_rev | input | 1 | Transfer direction: 0 forward, 1 reverse |
| port_irq | input | 1 | Current port interrupt state |
| mode_err | output | 1 | Stored control value breaks a software rule |
| svc_irq | output | 1 | One-cycle service interrupt in FIFO mode |

## Verification
The read data, the three status bits and the configuration view follow the inputs combinationally, in the same cycle as the inputs. A write reaches rdata and mode_err only after the next rising edge. The interrupt compares the service condition of the current cycle with the one registered at the previous edge. The bench drives inputs just after a falling edge and compares all outputs one nanosecond later, using a reference model that holds the state as it was before the coming edge. It updates that model at the rising edge, so a write is first expected to show one cycle after its strobe.

// File: rtl/ppctl_pkg.sv
package ppctl_pkg;

    typedef enum logic [2:0] {
        MODE_STD   = 3'b000,
        MODE_BIDIR = 3'b001,
        MODE_RSV_A = 3'b010,
        MODE_FIFO  = 3'b011,
        MODE_ENH   = 3'b100,
        MODE_RSV_B = 3'b101,
        MODE_TEST  = 3'b110,
        MODE_CFG   = 3'b111
    } port_mode_e;

    typedef struct packed {
        port_mode_e  mode;
        logic [4:0]  rsvd;
    } ctl_reg_t;

    typedef struct packed {
        logic svc;
        logic full;
        logic empty;
    } fifo_flags_t;

    localparam logic [4:0] RSVD_PATTERN = 5'b00001;
    localparam logic [1:0] ADDR_CTL     = 2'd0;
    localparam logic [1:0] ADDR_CFGB    = 2'd1;
    localparam int         CFGB_IRQ_BIT = 6;

    function automatic logic mode_is_reserved(input port_mode_e m);
        return (m == MODE_RSV_A) || (m == MODE_RSV_B);
    endfunction

    function automatic logic [7:0] ctl_readback(input ctl_reg_t c, input fifo_flags_t f);
        return {c.mode, c.rsvd[4:3], f.svc, f.full, f.empty};
    endfunction

endpackage

// File: rtl/ppctl_regs.sv
module ppctl_regs
    import ppctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_ctl,
    input  logic [7:0] wdata,
    output ctl_reg_t   ctl,
    output logic       err
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl.mode <= MODE_STD;
            ctl.rsvd <= RSVD_PATTERN;
        end else if (wr_ctl) begin
            ctl.mode <= port_mode_e'(wdata[7:5]);
            ctl.rsvd <= wdata[4:0];
        end
    end

    assign err = mode_is_reserved(ctl.mode) || (ctl.rsvd != RSVD_PATTERN);
endmodule

// File: rtl/ppctl_flags.sv
module ppctl_flags
    import ppctl_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int THRESH = 8,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic [CNT_W-1:0] count,
    input  logic             dir_rev,
    output fifo_flags_t      flags
);
    localparam int         CW      = CNT_W + 1;
    localparam logic [CW-1:0] DEPTH_V  = CW'(DEPTH);
    localparam logic [CW-1:0] THRESH_V = CW'(THRESH);

    logic [CW-1:0] held;
    logic [CW-1:0] space;

    assign held  = {1'b0, count};
    assign space = DEPTH_V - held;

    always_comb begin
        flags.empty = (held == '0);
        flags.full  = (held == DEPTH_V);
        flags.svc   = dir_rev ? (held >= THRESH_V) : (space >= THRESH_V);
    end
endmodule

// File: rtl/ppctl_svc_irq.sv
module ppctl_svc_irq (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic svc,
    output logic irq
);
    logic svc_prev;

    always_ff @(posedge clk) begin
        if (rst) svc_prev <= 1'b0;
        else     svc_prev <= svc;
    end

    assign irq = enable && svc && !svc_prev;
endmodule

// File: rtl/ppfifo_ctrl.sv
module ppfifo_ctrl
    import ppctl_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int THRESH = 8,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [1:0]       addr,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    input  logic [CNT_W-1:0] fifo_count,
    input  logic             dir_rev,
    input  logic             port_irq,
    output logic             mode_err,
    output logic             svc_irq
);
    ctl_reg_t    ctl;
    fifo_flags_t flags;
    logic [2:0]  mode_q;

    ppctl_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_ctl (wr_en && (addr == ADDR_CTL)),
        .wdata  (wdata),
        .ctl    (ctl),
        .err    (mode_err)
    );

    ppctl_flags #(.DEPTH(DEPTH), .THRESH(THRESH), .CNT_W(CNT_W)) u_flags (
        .count   (fifo_count),
        .dir_rev (dir_rev),
        .flags   (flags)
    );

    ppctl_svc_irq u_irq (
        .clk    (clk),
        .rst    (rst),
        .enable (ctl.mode == MODE_FIFO),
        .svc    (flags.svc),
        .irq    (svc_irq)
    );

    assign mode_q = ctl.mode;

    always_comb begin
        rdata = 8'h00;
        if (rd_en) begin
            unique case (addr)
                ADDR_CTL:  rdata = ctl_readback(ctl, flags);
                ADDR_CFGB: if (ctl.mode == MODE_CFG) rdata[CFGB_IRQ_BIT] = port_irq;
                default:   rdata = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/ppfifo_ctrl_chk.sv
module ppfifo_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic       rd_en,
    input logic [1:0] addr,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic       port_irq,
    input logic       mode_err,
    input logic       svc_irq,
    input logic [2:0] mode_q
);
    p_reset_mode_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mode_q == 3'b000 && !mode_err));

    p_write_mode_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 2'd0) |=> (mode_q == $past(wdata[7:5])));

    p_hold_mode_r2: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == 2'd0) |=> $stable(mode_q));

    p_cfgb_hidden_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == 2'd1 && mode_q != 3'b111) |-> (rdata == 8'h00));

    p_cfgb_view_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == 2'd1 && mode_q == 3'b111) |-> (rdata == {1'b0, port_irq, 6'b0}));

    p_err_reserved_r7: assert property (@(posedge clk) disable iff (rst)
        (mode_q == 3'b010 || mode_q == 3'b101) |-> mode_err);

    p_irq_mode_r8: assert property (@(posedge clk) disable iff (rst)
        svc_irq |-> (mode_q == 3'b011));

    p_irq_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        svc_irq |=> !svc_irq);

    p_idle_read_r9: assert property (@(posedge clk) disable iff (rst)
        (!rd_en || addr[1]) |-> (rdata == 8'h00));
endmodule

bind ppfifo_ctrl ppfifo_ctrl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .port_irq (port_irq),
    .mode_err (mode_err),
    .svc_irq  (svc_irq),
    .mode_q   (mode_q)
);

// File: tb/ppfifo_ctrl_test.sv
module ppfifo_ctrl_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [4:0] fifo_count = 5'd0;
    logic       dir_rev = 1'b0;
    logic       port_irq = 1'b0;
    logic       mode_err;
    logic       svc_irq;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    logic [2:0] m_mode = 3'b000;
    logic [4:0] m_rsvd = 5'b00001;
    logic       m_prev = 1'b0;

    always #2 clk = ~clk;

    ppfifo_ctrl uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .fifo_count(fifo_count), .dir_rev(dir_rev),
        .port_irq(port_irq), .mode_err(mode_err), .svc_irq(svc_irq)
    );

    function automatic logic f_svc(input logic [4:0] c, input logic d);
        return d ? (c >= 5'd8) : ((5'd16 - c) >= 5'd8);
    endfunction

    function automatic logic [7:0] f_rdata(input logic r, input logic [1:0] a,
                                           input logic [4:0] c, input logic d, input logic pi);
        if (!r) return 8'h00;
        if (a == 2'd0) return {m_mode, m_rsvd[4:3], f_svc(c, d), c == 5'd16, c == 5'd0};
        if (a == 2'd1) return (m_mode == 3'b111) ? {1'b0, pi, 6'b0} : 8'h00;
        return 8'h00;
    endfunction

    function automatic logic f_err();
        return (m_mode == 3'b010) || (m_mode == 3'b101) || (m_rsvd != 5'b00001);
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input string tag, input logic w, input logic r, input logic [1:0] a,
                        input logic [7:0] dv, input logic [4:0] c, input logic d, input logic pi);
        logic sv;
        @(negedge clk);
        wr_en = w; rd_en = r; addr = a; wdata = dv;
        fifo_count = c; dir_rev = d; port_irq = pi;
        #1;
        sv = f_svc(c, d);
        check({tag, " rdata"}, rdata, f_rdata(r, a, c, d, pi));
        check({tag, " R7 mode_err"}, {7'b0, mode_err}, {7'b0, f_err()});
        check({tag, " R8 svc_irq"}, {7'b0, svc_irq},
              {7'b0, (m_mode == 3'b011) && sv && !m_prev});
        @(posedge clk);
        if (w && a == 2'd0) begin
            m_mode = dv[7:5];
            m_rsvd = dv[4:0];
        end
        m_prev = sv;
    endtask

    initial begin
        #400000;
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234_5678));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state, forward, empty FIFO: svc=1 full=0 empty=1
        step("R1", 0, 1, 2'd0, 8'h00, 5'd0, 0, 0);
        check("R1 reset read", rdata, 8'h05);

        // R2: write and next-cycle visibility, reserved bits readback
        step("R2 write", 1, 1, 2'd0, 8'h99, 5'd3, 0, 0);
        step("R2 after", 0, 1, 2'd0, 8'h00, 5'd3, 0, 0);
        check("R2 readback", rdata, 8'h9C);

        // R3 R4 R5: count boundaries in both directions
        for (int d = 0; d < 2; d++) begin
            step("R3 R4 R5 bnd", 0, 1, 2'd0, 8'h00, 5'd0,  d[0], 0);
            step("R3 R4 R5 bnd", 0, 1, 2'd0, 8'h00, 5'd1,  d[0], 0);
            step("R3 R4 R5 bnd", 0, 1, 2'd0, 8'h00, 5'd7,  d[0], 0);
            step("R3 R4 R5 bnd", 0, 1, 2'd0, 8'h00, 5'd8,  d[0], 0);
            step("R3 R4 R5 bnd", 0, 1, 2'd0, 8'h00, 5'd9,  d[0], 0);
            step("R3 R4 R5 bnd", 0, 1, 2'd0, 8'h00, 5'd15, d[0], 0);
            step("R3 R4 R5 bnd", 0, 1, 2'd0, 8'h00, 5'd16, d[0], 0);
        end

        // R6: hidden in non-config mode, visible in config mode, address 1 write ignored
        step("R6 hidden", 0, 1, 2'd1, 8'h00, 5'd4, 0, 1);
        step("R6 cfg write", 1, 1, 2'd0, 8'hE1, 5'd4, 0, 1);
        step("R6 view irq1", 0, 1, 2'd1, 8'h00, 5'd4, 0, 1);
        check("R6 view irq1", rdata, 8'h40);
        step("R6 view irq0", 1, 1, 2'd1, 8'h21, 5'd4, 0, 0);
        step("R6 ignored wr", 0, 1, 2'd0, 8'h00, 5'd16, 0, 0);
        check("R6 ctl unchanged", rdata, 8'hE2);

        // R7: reserved mode codes and bad reserved field
        step("R7 rsv mode", 1, 1, 2'd0, 8'h41, 5'd0, 0, 0);
        step("R7 rsv mode", 1, 1, 2'd0, 8'hA1, 5'd0, 0, 0);
        step("R7 bad field", 1, 1, 2'd0, 8'h03, 5'd0, 0, 0);
        step("R7 ok", 1, 1, 2'd0, 8'h01, 5'd0, 0, 0);
        step("R7 ok", 0, 1, 2'd0, 8'h00, 5'd0, 0, 0);

        // R8: edge pulses in FIFO mode only
        step("R8 rise mode0", 0, 1, 2'd0, 8'h00, 5'd12, 0, 0);
        step("R8 rise mode0", 0, 1, 2'd0, 8'h00, 5'd8,  0, 0);
        step("R8 set fifo", 1, 1, 2'd0, 8'h61, 5'd12, 0, 0);
        step("R8 fall", 0, 1, 2'd0, 8'h00, 5'd12, 0, 0);
        step("R8 rise", 0, 1, 2'd0, 8'h00, 5'd8, 0, 0);
        check("R8 pulse", {7'b0, svc_irq}, 8'h01);
        step("R8 hold", 0, 1, 2'd0, 8'h00, 5'd8, 0, 0);
        step("R8 hold", 0, 1, 2'd0, 8'h00, 5'd4, 0, 0);
        step("R8 rev fall", 0, 1, 2'd0, 8'h00, 5'd4, 1, 0);
        step("R8 rev rise", 0, 1, 2'd0, 8'h00, 5'd9, 1, 0);

        // R9: idle read and unused addresses
        step("R9 idle", 0, 0, 2'd0, 8'h00, 5'd9, 1, 1);
        step("R9 addr2", 0, 1, 2'd2, 8'h00, 5'd9, 1, 1);
        step("R9 addr3", 0, 1, 2'd3, 8'h00, 5'd9, 1, 1);

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic       w;
            logic [7:0] dv;
            w  = ($urandom_range(0, 3) == 0);
            dv = $urandom_range(0, 255);
            if ($urandom_range(0, 1) == 0) dv[4:0] = 5'b00001;
            if ($urandom_range(0, 2) == 0) dv[7:5] = 3'b011;
            step("R2 R3 R4 R5 R6 R9 random", w, ($urandom_range(0, 7) != 0),
                 2'($urandom_range(0, 3)), dv, 5'($urandom_range(0, 16)),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule